// File: doc/BRIEF.md
# Accumulator ALU with Registered Flags

This block is the arithmetic and logic stage of a small 8-bit processor. Each cycle it takes the accumulator value, an 8-bit operand that the surrounding datapath has already fetched, and a 4-bit operation code. From these it forms a new accumulator value combinationally. It also holds the five condition flags (sign, zero, auxiliary carry, parity, carry) in a register. The flag register updates on the next rising clock edge, and only the flags that the chosen operation is defined to touch are written.

The datapath writes `res` back into the accumulator when `acc_we` is high. `flag_we` shows which flags the operation will write. The carry and auxiliary-carry inputs of the operations come from the block's own flag register. Flags are packed as `flags[4]` sign, `flags[3]` zero, `flags[2]` auxiliary carry, `flags[1]` parity and `flags[0]` carry. The operation codes are ADD 0, ADC 1, SUB 2, CMP 3, AND 4, INC 5, DEC 6, CPL 7, CMC 8, STC 9, RRC 10 and DAA 11. Codes 12 to 15 are unused.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-low reset clears all five flags. Flags change only on a rising edge where `op_valid` is 1, and only in the bits where `flag_we` is 1. With `op_valid` at 0, `acc_we` and `flag_we` are 0 and the flags hold.
- R2: ADD (0) and ADC (1) drive `res` to accumulator plus operand, with ADC also adding the carry flag. They write every flag: carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3.
- R3: SUB (2) drives `res` to accumulator minus operand and writes every flag. Carry is 1 when the accumulator is below the operand (a borrow). Auxiliary carry is 1 when the accumulator's low nibble is below the operand's low nibble.
- R4: CMP (3) keeps `acc_we` at 0 and writes every flag as SUB would. Carry is 1 when the accumulator is less than the operand, zero is 1 when they are equal, and both are 0 when the accumulator is greater.
- R5: AND (4) drives `res` to the bitwise AND and sets sign, zero and parity from it. It sets auxiliary carry to 1 and clears carry.
- R6: INC (5) and DEC (6) add or subtract one. They write sign, zero, parity and auxiliary carry (the carry or borrow across bit 3) and leave carry unchanged.
- R7: CPL (7) drives `res` to the inverted accumulator and writes no flag.
- R8: CMC (8) inverts carry and STC (9) sets carry to 1. Both keep `acc_we` at 0 and leave the other four flags unchanged.
- R9: RRC (10) drives `res` to the old carry in bit 7 with accumulator bits 7..1 shifted down into bits 6..0. It loads accumulator bit 0 into carry, and no other flag changes.
- R10: DAA (11) adds 6 when the low nibble is above 9 or auxiliary carry is 1. It then adds 0x60 when the resulting high nibble is above 9 or carry is 1. Auxiliary carry becomes the carry out of bit 3 from the first step. Carry is set if either step carries out of bit 7 and otherwise keeps its value. Sign, zero and parity follow the result.
- R11: For every operation that writes them, sign is bit 7 of the result, zero is 1 for a zero result, and parity is 1 when the result has an even number of 1 bits.
- R12: Operation codes 12 to 15 drive `acc_we` and `flag_we` to 0 and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator value |
| opnd | input | 8 | Operand byte |
| res | output | 8 | New accumulator value (combinational) |
| acc_we | output | 1 | Accumulator write enable |
| flag_we | output | 5 | Per-flag write enable, same packing as `flags` |
| flags | output | 5 | Registered flags {sign, zero, aux, parity, carry} |

## Verification
On every cycle, the assertions check the following:
- Sign, zero and parity match the previous cycle's result whenever they are written.
- Flags hold when no operation is present.
- CMP never requests an accumulator write.
- The flag-only operations and the rotate touch nothing but carry.
- Complement and the unused codes leave the flags alone.

The arithmetic values themselves can only be shown by the bench's directed scenarios. These cover carry and half-carry across bits 3 and 7, borrows on subtract and compare, the three outcomes of compare, and the two-step decimal adjust with its carry kept or set.

// File: rtl/acc_alu_pkg.sv
// Package: shared widths, flag bit positions and operation codes for the
// accumulator ALU. Assumes an 8-bit datapath split into two 4-bit nibbles.
package acc_alu_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned NIB_W  = DATA_W / 2;
    localparam int unsigned FLAG_N = 5;

    // Flag positions inside the packed flag vector
    localparam int unsigned FL_CY   = 0;
    localparam int unsigned FL_PAR  = 1;
    localparam int unsigned FL_AUX  = 2;
    localparam int unsigned FL_ZERO = 3;
    localparam int unsigned FL_SIGN = 4;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_CMP = 4'd3,
        OP_AND = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_CPL = 4'd7,
        OP_CMC = 4'd8,
        OP_STC = 4'd9,
        OP_RRC = 4'd10,
        OP_DAA = 4'd11
    } alu_op_e;

    // Even parity: 1 when the value holds an even count of set bits
    function automatic logic even_par(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
// Module: shared adder/subtractor for ADD, ADC, SUB, CMP, INC and DEC.
// Produces the result, the carry (or borrow) out of the top bit and the
// carry (or borrow) across the nibble boundary. Assumes cin is 0 or 1.
module acc_alu_addsub #(
    parameter int unsigned W  = 8,
    parameter int unsigned NW = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hcout
);
    logic [W:0]  full_r;
    logic [NW:0] nib_r;

    // Wide and nibble-wide operations; the extra bit is carry or borrow
    always_comb begin
        if (sub) begin
            full_r = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            nib_r  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
        end else begin
            full_r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            nib_r  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        end
    end

    assign sum   = full_r[W-1:0];
    assign cout  = full_r[W];
    assign hcout = nib_r[NW];

endmodule

// File: rtl/acc_alu_bitops.sv
// Module: bitwise results for AND, complement and rotate right through carry.
// Assumes the caller supplies the current carry flag as cy.
module acc_alu_bitops #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cy,
    output logic [W-1:0] and_r,
    output logic [W-1:0] cpl_r,
    output logic [W-1:0] rrc_r
);
    // Pure wiring of the three bitwise results
    assign and_r = a & b;
    assign cpl_r = ~a;
    assign rrc_r = {cy, a[W-1:1]};

endmodule

// File: rtl/acc_alu_decadj.sv
// Module: two-step decimal adjust of the accumulator after BCD addition.
// The low step looks at the low nibble and aux carry. The high step looks at
// the partially adjusted high nibble and carry. Assumes an 8-bit value.
module acc_alu_decadj
    import acc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic              ac_in,
    input  logic              cy_in,
    output logic [DATA_W-1:0] r,
    output logic              ac_out,
    output logic              cy_out
);
    localparam logic [NIB_W-1:0] BCD_MAX = NIB_W'(9);
    localparam logic [NIB_W-1:0] ADJ     = NIB_W'(6);

    logic              lo_fix;
    logic              hi_fix;
    logic [NIB_W:0]    lo_sum;
    logic [DATA_W:0]   step1;
    logic [DATA_W:0]   step2;

    // Low-nibble correction step and its half carry
    always_comb begin
        lo_fix = (a[NIB_W-1:0] > BCD_MAX) || ac_in;
        lo_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, (lo_fix ? ADJ : '0)};
        step1  = {1'b0, a} + {{(DATA_W-NIB_W+1){1'b0}}, (lo_fix ? ADJ : '0)};
    end

    // High-nibble correction step on the partially adjusted value
    always_comb begin
        hi_fix = (step1[DATA_W-1:NIB_W] > BCD_MAX) || cy_in || step1[DATA_W];
        step2  = {1'b0, step1[DATA_W-1:0]}
               + {1'b0, (hi_fix ? ADJ : '0), {NIB_W{1'b0}}};
    end

    assign r      = step2[DATA_W-1:0];
    assign ac_out = lo_fix & lo_sum[NIB_W];
    assign cy_out = cy_in | step1[DATA_W] | step2[DATA_W];

endmodule

// File: rtl/acc_alu_flagreg.sv
// Module: per-bit enabled flag register with synchronous active-low reset.
// Each bit loads its next value only when the update strobe and its own
// enable are both high.
module acc_alu_flagreg #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [N-1:0] we,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        logic bit_q;
        // Hold or load one flag bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (upd && we[gi])
                bit_q <= d[gi];
        end
        assign q[gi] = bit_q;
    end

endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU top. Decodes the operation, steers the operands
// into the shared adder, selects the result and builds the per-flag write
// enables and next flag values. Assumes the operand was fetched earlier and
// that the datapath stores res into the accumulator when acc_we is high.
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] res,
    output logic              acc_we,
    output logic [FLAG_N-1:0] flag_we,
    output logic [FLAG_N-1:0] flags
);
    localparam logic [FLAG_N-1:0] WE_ALL   = '1;
    localparam logic [FLAG_N-1:0] WE_CARRY = FLAG_N'(1) << FL_CY;
    localparam logic [FLAG_N-1:0] WE_NO_CY = WE_ALL & ~WE_CARRY;

    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic              add_sub;
    logic [DATA_W-1:0] add_r;
    logic              add_co;
    logic              add_hc;
    logic [DATA_W-1:0] and_r;
    logic [DATA_W-1:0] cpl_r;
    logic [DATA_W-1:0] rrc_r;
    logic [DATA_W-1:0] daa_r;
    logic              daa_ac;
    logic              daa_cy;
    logic [DATA_W-1:0] alu_r;
    logic              awe_c;
    logic [FLAG_N-1:0] we_c;
    logic [FLAG_N-1:0] nf_c;

    acc_alu_addsub #(.W(DATA_W), .NW(NIB_W)) u_addsub (
        .a     (acc_in),
        .b     (add_b),
        .cin   (add_cin),
        .sub   (add_sub),
        .sum   (add_r),
        .cout  (add_co),
        .hcout (add_hc)
    );

    acc_alu_bitops #(.W(DATA_W)) u_bitops (
        .a     (acc_in),
        .b     (opnd),
        .cy    (flags[FL_CY]),
        .and_r (and_r),
        .cpl_r (cpl_r),
        .rrc_r (rrc_r)
    );

    acc_alu_decadj u_decadj (
        .a      (acc_in),
        .ac_in  (flags[FL_AUX]),
        .cy_in  (flags[FL_CY]),
        .r      (daa_r),
        .ac_out (daa_ac),
        .cy_out (daa_cy)
    );

    // Operation decode: adder steering, result select, enables, carry/aux
    always_comb begin
        add_b   = opnd;
        add_cin = 1'b0;
        add_sub = 1'b0;
        alu_r   = acc_in;
        awe_c   = 1'b0;
        we_c    = '0;
        nf_c    = flags;
        case (op)
            OP_ADD, OP_ADC: begin
                add_cin        = (op == OP_ADC) ? flags[FL_CY] : 1'b0;
                alu_r          = add_r;
                awe_c          = 1'b1;
                we_c           = WE_ALL;
                nf_c[FL_CY]    = add_co;
                nf_c[FL_AUX]   = add_hc;
            end
            OP_SUB, OP_CMP: begin
                add_sub        = 1'b1;
                alu_r          = add_r;
                awe_c          = (op == OP_SUB);
                we_c           = WE_ALL;
                nf_c[FL_CY]    = add_co;
                nf_c[FL_AUX]   = add_hc;
            end
            OP_AND: begin
                alu_r          = and_r;
                awe_c          = 1'b1;
                we_c           = WE_ALL;
                nf_c[FL_CY]    = 1'b0;
                nf_c[FL_AUX]   = 1'b1;
            end
            OP_INC, OP_DEC: begin
                add_b          = '0;
                add_cin        = 1'b1;
                add_sub        = (op == OP_DEC);
                alu_r          = add_r;
                awe_c          = 1'b1;
                we_c           = WE_NO_CY;
                nf_c[FL_AUX]   = add_hc;
            end
            OP_CPL: begin
                alu_r          = cpl_r;
                awe_c          = 1'b1;
            end
            OP_CMC: begin
                we_c           = WE_CARRY;
                nf_c[FL_CY]    = ~flags[FL_CY];
            end
            OP_STC: begin
                we_c           = WE_CARRY;
                nf_c[FL_CY]    = 1'b1;
            end
            OP_RRC: begin
                alu_r          = rrc_r;
                awe_c          = 1'b1;
                we_c           = WE_CARRY;
                nf_c[FL_CY]    = acc_in[0];
            end
            OP_DAA: begin
                alu_r          = daa_r;
                awe_c          = 1'b1;
                we_c           = WE_ALL;
                nf_c[FL_CY]    = daa_cy;
                nf_c[FL_AUX]   = daa_ac;
            end
            default: begin
                awe_c          = 1'b0;
            end
        endcase
        nf_c[FL_SIGN] = alu_r[DATA_W-1];
        nf_c[FL_ZERO] = (alu_r == '0);
        nf_c[FL_PAR]  = even_par(alu_r);
    end

    // Gate the enables with the operation strobe
    assign res     = alu_r;
    assign acc_we  = op_valid & awe_c;
    assign flag_we = op_valid ? we_c : '0;

    acc_alu_flagreg #(.N(FLAG_N)) u_flagreg (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (op_valid),
        .we    (we_c),
        .d     (nf_c),
        .q     (flags)
    );

endmodule

// File: rtl/acc_alu_chk.sv
// Module: property checker bound to the accumulator ALU top. It observes the
// ports only and checks the flag update rules over consecutive cycles.
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd,
    input logic [DATA_W-1:0] res,
    input logic              acc_we,
    input logic [FLAG_N-1:0] flag_we,
    input logic [FLAG_N-1:0] flags
);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags));

    p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CMP) |-> !acc_we);

    p_and_aux_cy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_AND) |=> (flags[FL_AUX] && !flags[FL_CY]));

    p_incdec_keep_cy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_INC || op == OP_DEC)) |=> flags[FL_CY] == $past(flags[FL_CY]));

    p_cpl_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CPL) |=> $stable(flags));

    p_cy_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_CMC || op == OP_STC)) |=> flags[FLAG_N-1:1] == $past(flags[FLAG_N-1:1]));

    p_stc_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_STC) |=> flags[FL_CY]);

    p_rrc_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_RRC) |=> (flags[FL_CY] == $past(acc_in[0])
                                        && flags[FLAG_N-1:1] == $past(flags[FLAG_N-1:1])));

    p_zero_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_we[FL_ZERO]) |=> flags[FL_ZERO] == ($past(res) == '0));

    p_sign_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_we[FL_SIGN]) |=> flags[FL_SIGN] == $past(res[DATA_W-1]));

    p_par_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_we[FL_PAR]) |=> flags[FL_PAR] == ($countones($past(res)) % 2 == 0));

    p_unused_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op > OP_DAA) |=> $stable(flags));

endmodule

bind acc_alu acc_alu_chk u_chk (.*);

// File: tb/acc_alu_bench.sv
// Directed bench for the accumulator ALU: one task per scenario.
module acc_alu_bench;
    localparam time CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [3:0] op;
    logic [7:0] acc_in;
    logic [7:0] opnd;
    logic [7:0] res;
    logic       acc_we;
    logic [4:0] flag_we;
    logic [4:0] flags;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .acc_in(acc_in), .opnd(opnd), .res(res), .acc_we(acc_we),
        .flag_we(flag_we), .flags(flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation at a falling edge; flags packed {S,Z,AC,P,CY}
    task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic chk_res, input logic [7:0] er, input logic eawe,
                          input logic [4:0] ef, input string tag);
        op_valid = 1'b1; op = o; acc_in = a; opnd = b;
        #1;
        if (chk_res) check({tag, " res"}, res, er);
        check({tag, " acc_we"}, {7'd0, acc_we}, {7'd0, eawe});
        @(negedge clk);
        check({tag, " flags"}, {3'd0, flags}, {3'd0, ef});
    endtask

    task automatic t_reset();
        rst_n = 1'b0; op_valid = 1'b0; op = 4'd0; acc_in = '0; opnd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset flags", {3'd0, flags}, 8'h00);
    endtask

    task automatic t_add();
        run_op(4'd0, 8'h3A, 8'hC6, 1, 8'h00, 1, 5'b01111, "R2 R11 add wrap");
        run_op(4'd1, 8'h10, 8'h20, 1, 8'h31, 1, 5'b00000, "R2 adc carry in");
    endtask

    task automatic t_sub_cmp();
        run_op(4'd2, 8'h05, 8'h07, 1, 8'hFE, 1, 5'b10101, "R3 sub borrow");
        run_op(4'd3, 8'h40, 8'h40, 0, 8'h00, 0, 5'b01010, "R4 cmp equal");
        run_op(4'd3, 8'h20, 8'h40, 0, 8'h00, 0, 5'b10001, "R4 cmp less");
        run_op(4'd3, 8'h80, 8'h01, 0, 8'h00, 0, 5'b00100, "R4 cmp greater");
    endtask

    task automatic t_and();
        run_op(4'd4, 8'hF0, 8'h3C, 1, 8'h30, 1, 5'b00110, "R5 and");
        run_op(4'd9, 8'h00, 8'h00, 0, 8'h00, 0, 5'b00111, "R8 stc");
    endtask

    task automatic t_incdec();
        run_op(4'd5, 8'h0F, 8'h99, 1, 8'h10, 1, 5'b00101, "R6 inc half carry");
        run_op(4'd6, 8'h00, 8'h99, 1, 8'hFF, 1, 5'b10111, "R6 dec wrap");
    endtask

    task automatic t_cpl_carry();
        run_op(4'd7, 8'h5A, 8'h00, 1, 8'hA5, 1, 5'b10111, "R7 cpl");
        run_op(4'd8, 8'h00, 8'h00, 0, 8'h00, 0, 5'b10110, "R8 cmc clear");
        run_op(4'd8, 8'h00, 8'h00, 0, 8'h00, 0, 5'b10111, "R8 cmc set");
    endtask

    task automatic t_rrc();
        run_op(4'd10, 8'h02, 8'h00, 1, 8'h81, 1, 5'b10110, "R9 rrc carry in");
        run_op(4'd10, 8'h03, 8'h00, 1, 8'h01, 1, 5'b10111, "R9 rrc carry out");
    endtask

    task automatic t_daa();
        run_op(4'd0, 8'h38, 8'h49, 1, 8'h81, 1, 5'b10110, "R2 bcd add");
        run_op(4'd11, 8'h81, 8'h00, 1, 8'h87, 1, 5'b10010, "R10 daa aux");
        run_op(4'd11, 8'h9B, 8'h00, 1, 8'h01, 1, 5'b00101, "R10 daa both nibbles");
        run_op(4'd11, 8'h12, 8'h00, 1, 8'h78, 1, 5'b00011, "R10 daa carry kept");
    endtask

    task automatic t_unused_idle();
        op_valid = 1'b1; op = 4'd13; acc_in = 8'hFF; opnd = 8'hFF;
        #1;
        check("R12 unused we", {2'd0, acc_we, flag_we}, 8'h00);
        @(negedge clk);
        check("R12 unused flags", {3'd0, flags}, 8'h03);
        op_valid = 1'b0; op = 4'd0; acc_in = 8'h00; opnd = 8'h00;
        #1;
        check("R1 idle we", {2'd0, acc_we, flag_we}, 8'h00);
        @(negedge clk);
        check("R1 idle flags", {3'd0, flags}, 8'h03);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub_cmp();
        t_and();
        t_incdec();
        t_cpl_carry();
        t_rrc();
        t_daa();
        t_unused_idle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule